// File: doc/BRIEF.md
# Parity-Mixed Xoroshiro Random Word Generator

This block is a compact pseudo-random number generator for a 32-bit xoroshiro-style state, kept as two 16-bit halves. Each time a step is requested it registers a 16-bit result and advances the state on the same clock edge. The result is formed from the state as it was before the update. It is the 16-bit sum of the two halves, with one of its bits swapped for a parity bit. That parity is the XOR of the sum bits, and by default it includes the carry-out. The raw low bit of a plain sum is the statistically weakest bit, and the parity bit takes its place.

Software or surrounding logic seeds the generator through a 32-bit load port. It then pulses a step request whenever it wants a fresh word. The result appears one clock later with a one-cycle valid strobe. Parameters select the rotate/shift constant triple, whether the parity includes the carry, and whether the parity bit goes to the bottom or the top output position. The all-zero state is a fixed point of the update, so the block never enters it.

Top module: `xoro_prng`

## Requirements
- R1: While `rst` is high at a clock edge, the state is loaded with `RESET_SEED`, `out_valid` goes low and `out_data` goes to zero. The first step after reset therefore produces the word computed from `RESET_SEED`.
- R2: When `seed_valid` is high at a clock edge, the state takes `seed`, with the first half s0 taken from `seed[15:0]` and the second half s1 taken from `seed[31:16]`. `out_valid` is low in the following cycle.
- R3: A seed of all zeros is replaced by the nonzero constant `ZERO_SEED` (default 32'hBB67_AE85).
- R4: When `seed_valid` and `step` are both high in the same cycle, only the seed load takes effect. No output word is produced, `out_valid` stays low in the next cycle, and the next step uses the loaded seed.
- R5: A step sampled at a clock edge raises `out_valid` for exactly one cycle after that edge. `out_data` holds the word computed from the state before that step. Bits 15..1 of the word are bits 15..1 of s0+s1, and bit 0 is the XOR of all 17 bits of that sum including the carry.
- R6: On each step, with t = s1 ^ s0, the new state is s0' = rotl(s0,a) ^ t ^ (t << b) and s1' = rotl(t,c), all 16-bit. The default triple (a,b,c) is (14,2,7).
- R7: In a cycle with neither step nor seed load, the state is unchanged, `out_valid` is low and `out_data` keeps its last value.
- R8: With `PAR_CARRY` = 0, the parity is taken over the 16 sum bits only, and the carry is ignored.
- R9: With `PAR_MSB` = 1, the parity replaces bit 15, and bits 14..0 are the raw sum bits 14..0.
- R10: With `CONST_SET` = 1, the triple (a,b,c) is (15,3,6).
- R11: The state never becomes all zeros, so from any nonzero seed the sequence repeats only after 2^32-1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_valid | input | 1 | Load `seed` into the state this cycle |
| seed | input | 32 | Seed value; [15:0] is s0, [31:16] is s1 |
| step | input | 1 | Request one output word and one state advance |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |
| out_data | output | 16 | Registered output word |

## Verification
The assertions take for granted that `seed` is fully driven whenever `seed_valid` is high. They also assume that `rst` is held for at least one clock edge before any seed or step, so that the state starts at a known nonzero value. The stimulus changes inputs only just after a rising edge. It asserts reset first and always drives `seed` with a defined value, including the zero seed and a seed whose halves produce a carry-out. Two instances with opposite parameter choices share the same input stream, so both parity placements, both parity widths and both constant triples are exercised against the same state history.

// File: rtl/xoro_pkg.sv
package xoro_pkg;

    typedef struct packed {
        logic [4:0] rot_a;
        logic [4:0] shl_b;
        logic [4:0] rot_c;
    } shift_set_t;

    // Set 0 is the default triple; set 1 is the alternative.
    function automatic shift_set_t pick_shifts(input int unsigned set_sel);
        shift_set_t r;
        if (set_sel == 1) begin
            r.rot_a = 5'd15;
            r.shl_b = 5'd3;
            r.rot_c = 5'd6;
        end else begin
            r.rot_a = 5'd14;
            r.shl_b = 5'd2;
            r.rot_c = 5'd7;
        end
        return r;
    endfunction

endpackage

// File: rtl/xoro_next.sv
module xoro_next #(
    parameter int W = 16,
    parameter int A = 14,
    parameter int B = 2,
    parameter int C = 7
) (
    input  logic [W-1:0] s0_i,
    input  logic [W-1:0] s1_i,
    output logic [W-1:0] s0_o,
    output logic [W-1:0] s1_o
);
    logic [W-1:0] mix;
    logic [W-1:0] rot_s0;
    logic [W-1:0] rot_mix;

    always_comb begin
        mix     = s1_i ^ s0_i;
        rot_s0  = (s0_i << A) | (s0_i >> (W - A));
        rot_mix = (mix << C) | (mix >> (W - C));
        s0_o    = rot_s0 ^ mix ^ (mix << B);
        s1_o    = rot_mix;
    end
endmodule

// File: rtl/xoro_mix.sv
module xoro_mix #(
    parameter int W         = 16,
    parameter bit PAR_CARRY = 1'b1,
    parameter bit PAR_MSB   = 1'b0
) (
    input  logic [W-1:0] s0_i,
    input  logic [W-1:0] s1_i,
    output logic [W-1:0] word_o
);
    logic [W:0] sum;
    logic       par;

    always_comb begin
        sum = {1'b0, s0_i} + {1'b0, s1_i};
        par = PAR_CARRY ? (^sum) : (^sum[W-1:0]);
    end

    generate
        if (PAR_MSB) begin : g_top_par
            assign word_o = {par, sum[W-2:0]};
        end else begin : g_low_par
            assign word_o = {sum[W-1:1], par};
        end
    endgenerate
endmodule

// File: rtl/xoro_prng.sv
module xoro_prng #(
    parameter int              W          = 16,
    parameter int unsigned     CONST_SET  = 0,
    parameter bit              PAR_CARRY  = 1'b1,
    parameter bit              PAR_MSB    = 1'b0,
    parameter logic [2*W-1:0]  RESET_SEED = 32'h6A09_E667,
    parameter logic [2*W-1:0]  ZERO_SEED  = 32'hBB67_AE85
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           seed_valid,
    input  logic [2*W-1:0] seed,
    input  logic           step,
    output logic           out_valid,
    output logic [W-1:0]   out_data
);
    import xoro_pkg::*;

    localparam shift_set_t SH = pick_shifts(CONST_SET);
    localparam int SA = int'(SH.rot_a);
    localparam int SB = int'(SH.shl_b);
    localparam int SC = int'(SH.rot_c);

    typedef struct packed {
        logic [W-1:0] s0;
        logic [W-1:0] s1;
        logic [W-1:0] dat;
        logic         vld;
    } regs_t;

    regs_t        r_q, r_d;
    logic [W-1:0] s0_nx, s1_nx;
    logic [W-1:0] word;
    logic [2*W-1:0] seed_fix;

    xoro_next #(.W(W), .A(SA), .B(SB), .C(SC)) u_next (
        .s0_i (r_q.s0),
        .s1_i (r_q.s1),
        .s0_o (s0_nx),
        .s1_o (s1_nx)
    );

    xoro_mix #(.W(W), .PAR_CARRY(PAR_CARRY), .PAR_MSB(PAR_MSB)) u_mix (
        .s0_i   (r_q.s0),
        .s1_i   (r_q.s1),
        .word_o (word)
    );

    always_comb begin
        seed_fix = (seed == '0) ? ZERO_SEED : seed;
        r_d      = r_q;
        r_d.vld  = 1'b0;
        if (seed_valid) begin
            r_d.s0 = seed_fix[W-1:0];
            r_d.s1 = seed_fix[2*W-1:W];
        end else if (step) begin
            r_d.s0  = s0_nx;
            r_d.s1  = s1_nx;
            r_d.dat = word;
            r_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.s0  <= RESET_SEED[W-1:0];
            r_q.s1  <= RESET_SEED[2*W-1:W];
            r_q.dat <= '0;
            r_q.vld <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.vld;
    assign out_data  = r_q.dat;

    // R11: state never collapses to zero
    p_state_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
        {r_q.s1, r_q.s0} != '0);

    // R2 and R4: a load suppresses the output strobe
    p_load_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
        seed_valid |=> !out_valid);

    // R3: zero seed is replaced
    p_zero_seed_r3: assert property (@(posedge clk) disable iff (rst)
        (seed_valid && seed == '0) |=> ({r_q.s1, r_q.s0} == ZERO_SEED));

    // R2: nonzero seed lands in the state as given
    p_seed_load_r2: assert property (@(posedge clk) disable iff (rst)
        (seed_valid && seed != '0) |=> ({r_q.s1, r_q.s0} == $past(seed)));

    // R5: a lone step gives one strobe
    p_step_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !seed_valid) |=> out_valid);

    // R7: idle cycles leave state and data alone
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!step && !seed_valid) |=> ($stable(r_q.s0) && $stable(r_q.s1)
                                     && $stable(out_data) && !out_valid));
endmodule

// File: tb/tb_xoro_prng.sv
module tb_xoro_prng;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_valid = 1'b0;
    logic [31:0] seed = '0;
    logic        step = 1'b0;
    logic        va, vb;
    logic [15:0] da, db;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] RST_SEED = 32'h6A09_E667;
    localparam logic [31:0] ZSEED    = 32'hBB67_AE85;

    always #5 clk = ~clk;

    xoro_prng dut (
        .clk(clk), .rst(rst), .seed_valid(seed_valid), .seed(seed),
        .step(step), .out_valid(va), .out_data(da)
    );

    xoro_prng #(.CONST_SET(1), .PAR_CARRY(1'b0), .PAR_MSB(1'b1)) dut_b (
        .clk(clk), .rst(rst), .seed_valid(seed_valid), .seed(seed),
        .step(step), .out_valid(vb), .out_data(db)
    );

    typedef struct {
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t q_a[$];
    item_t q_b[$];

    logic [31:0] ma, mb;    // model states {s1,s0}
    logic [15:0] last_a;
    string       cur_tag;

    function automatic logic [15:0] rl(input logic [15:0] x, input int k);
        return (x << k) | (x >> (16 - k));
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] st, input int a, input int b, input int c);
        logic [15:0] s0, s1, t;
        s0 = st[15:0];
        s1 = st[31:16];
        t  = s1 ^ s0;
        return {rl(t, c), rl(s0, a) ^ t ^ (t << b)};
    endfunction

    function automatic logic [15:0] wordof(input logic [31:0] st, input bit withc, input bit msb);
        logic [16:0] s;
        logic        p;
        s = {1'b0, st[15:0]} + {1'b0, st[31:16]};
        p = withc ? ^s : ^s[15:0];
        return msb ? {p, s[14:0]} : {s[15:1], p};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit sv, input logic [31:0] sd, input bit st);
        item_t it;
        seed_valid = sv;
        seed       = sd;
        step       = st;
        if (sv) begin
            ma = (sd == 0) ? ZSEED : sd;
            mb = ma;
        end else if (st) begin
            it.val = wordof(ma, 1'b1, 1'b0);
            it.tag = cur_tag;
            q_a.push_back(it);
            last_a = it.val;
            it.val = wordof(mb, 1'b0, 1'b1);
            it.tag = "R8 R9 R10";
            q_b.push_back(it);
            ma = adv(ma, 14, 2, 7);
            mb = adv(mb, 15, 3, 6);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 32'h0, 1'b0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 32'h0, 1'b1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (va) begin
                if (q_a.size() == 0) check(1'b0, "R4 unexpected valid (dut)", {16'h0, da}, 32'h0);
                else begin
                    item_t e;
                    e = q_a.pop_front();
                    check(da == e.val, e.tag, {16'h0, da}, {16'h0, e.val});
                end
            end
            if (vb) begin
                if (q_b.size() == 0) check(1'b0, "R4 unexpected valid (dut_b)", {16'h0, db}, 32'h0);
                else begin
                    item_t e;
                    e = q_b.pop_front();
                    check(db == e.val, e.tag, {16'h0, db}, {16'h0, e.val});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ma = RST_SEED;
        mb = RST_SEED;
        last_a = '0;
        cur_tag = "R1 R5 R6";
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!va && !vb && da == 16'h0, "R1 reset outputs", {va, vb, da}, 32'h0);
        @(posedge clk);
        #1;
        rst = 1'b0;

        steps(5);
        idle(3);
        @(negedge clk);
        check(!va && da == last_a, "R7 idle hold", {va, da}, {1'b0, last_a});
        @(posedge clk);
        #1;
        cur_tag = "R7 R6 state kept over idle";
        steps(3);

        cur_tag = "R2 R5";
        drive(1'b1, 32'h0001_0000, 1'b0);
        @(negedge clk);
        check(!va, "R2 no valid after load", {31'h0, va}, 32'h0);
        @(posedge clk);
        #1;
        steps(4);

        cur_tag = "R3 zero seed substitute";
        drive(1'b1, 32'h0, 1'b0);
        steps(4);

        cur_tag = "R4 seed wins over step";
        drive(1'b1, 32'hDEAD_BEEF, 1'b1);
        @(negedge clk);
        check(!va && !vb, "R4 no valid on seed+step", {va, vb}, 32'h0);
        @(posedge clk);
        #1;
        steps(3);

        cur_tag = "R5 carry into parity";
        drive(1'b1, 32'h0001_FFFF, 1'b0);
        steps(1);
        drive(1'b1, 32'hFFFF_FFFF, 1'b0);
        steps(2);

        cur_tag = "R11 R6 long run";
        for (int k = 0; k < 2000; k++) begin
            drive(1'b0, 32'h0, 1'b1);
            if (k % 7 == 3) idle(1);
        end
        idle(3);

        check(q_a.size() == 0 && q_b.size() == 0, "R5 all words delivered",
              q_a.size() + q_b.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule